// File: doc/BRIEF.md
# Configuration Invalidation Command Sequencer

This block sits between the command decoder of an I/O memory management unit and the caches that hold configuration-derived state. It takes one configuration-invalidation command at a time and turns it into invalidation strobes. Each strobe reaches the central configuration cache and both per-device translation caches, a small micro cache and a larger main cache, at every one of `NUM_DEV` device interfaces, all in the same cycle. Because a hit in a per-device cache skips the configuration stage, leaving those caches out of an invalidation would leave stale translations in use after the configuration tables change.

Four command kinds are accepted. One clears a single stream ID. One clears a stream ID plus substream ID pair. One clears every substream of a stream ID. One carries a range field: its all-ones value clears everything, and any other value names an aligned power-of-two block of stream IDs. The block walks that range one stream ID per cycle. The strobe bundle is registered and shared by all targets, and each target has its own valid line. The controller has two states. `ST_IDLE` accepts commands, and every non-range command finishes in one cycle. `ST_IDLE -> ST_WALK` is taken when a range command other than the all-ones form is accepted. `ST_WALK -> ST_IDLE` is taken in the cycle the walk counter reaches the last stream ID of the block, and `ST_WALK` holds otherwise.

Top module: `cfg_inval_seq`

## Requirements
- R1: A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. Command codes: 1 = single stream, 2 = range, 3 = stream plus substream, 4 = all substreams of a stream.
- R2: A code-1 command produces, in the cycle after acceptance, exactly one strobe with `inv_op` 0 (by stream), `inv_sid` equal to the command stream ID and `inv_ssid` 0.
- R3: A code-3 command produces one strobe in the next cycle with `inv_op` 1 (by stream and substream), carrying both the command stream ID and the command substream ID.
- R4: A code-4 command produces one strobe in the next cycle with `inv_op` 0, carrying the command stream ID and `inv_ssid` 0, so every substream of that stream is cleared.
- R5: A code-2 command whose range field is 31 produces one strobe in the next cycle with `inv_op` 2 (everything), `inv_sid` 0 and `inv_ssid` 0.
- R6: A code-2 command with range r below 31 produces strobes with `inv_op` 0, one per consecutive cycle starting the cycle after acceptance. They run in ascending order from first = stream ID with its low r+1 bits cleared up to first + 2^(r+1) - 1 inclusive.
- R7: `cmd_ready` is low from the cycle after a range command is accepted until the cycle in which its last strobe is driven. A command held on the inputs meanwhile is not taken.
- R8: A range whose last stream ID is the top of the 32-bit ID space ends there without wrapping to zero.
- R9: `cmd_done` is high for one cycle per command, in the cycle of that command's last strobe.
- R10: Codes 0, 5, 6 and 7 are accepted, produce no strobe, and raise `cmd_done` in the cycle after acceptance.
- R11: While reset is asserted and directly after it, no strobe valid and no `cmd_done` are high, and `cmd_ready` is high.
- R12: In every cycle the configuration cache valid and all `2*NUM_DEV` per-device valids are either all high or all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer can take a command |
| cmd_op | input | 3 | Command code |
| cmd_sid | input | SID_W | Command stream ID |
| cmd_ssid | input | SSID_W | Command substream ID |
| cmd_range | input | RANGE_W | Range field of a range command |
| cc_inv_vld | output | 1 | Strobe to the configuration cache |
| utlb_inv_vld | output | NUM_DEV | Strobe to each interface micro cache |
| mtlb_inv_vld | output | NUM_DEV | Strobe to each interface main cache |
| inv_op | output | 2 | Strobe kind: 0 by stream, 1 by stream and substream, 2 everything |
| inv_sid | output | SID_W | Strobe stream ID |
| inv_ssid | output | SSID_W | Strobe substream ID |
| cmd_done | output | 1 | Last strobe of a command is being driven |

## Verification
The bench aims at the edges of the range walk: the smallest range of two IDs, misaligned stream IDs that must be rounded down, and a block ending at the all-ones ID. A design that got these wrong would start at the raw ID, drop or repeat the last ID, or wrap and keep walking from zero. Commands are held on the inputs while a walk is running, so a sequencer that raised ready too early would take the command and interleave its strobe into the walk. Unknown codes and the all-ones range are mixed with back-to-back single commands. A design that strobed on an unknown code, walked an "everything" command, or missed an interface valid would break the expected per-cycle trace.

// File: rtl/cfg_inval_pkg.sv
package cfg_inval_pkg;

    // command codes
    localparam logic [2:0] CMD_ONE_SID   = 3'd1;
    localparam logic [2:0] CMD_SID_RANGE = 3'd2;
    localparam logic [2:0] CMD_SID_SSID  = 3'd3;
    localparam logic [2:0] CMD_SID_ALLSS = 3'd4;

    // strobe kind on inv_op
    typedef enum logic [1:0] {
        INV_BY_SID      = 2'd0,
        INV_BY_SID_SSID = 2'd1,
        INV_EVERYTHING  = 2'd2
    } inv_kind_e;

    // how the controller handles an accepted command
    typedef enum logic [1:0] {
        PLAN_SINGLE = 2'd0,
        PLAN_WALK   = 2'd1,
        PLAN_NONE   = 2'd2
    } cmd_plan_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } seq_state_e;

endpackage

// File: rtl/cfg_inval_decode.sv
module cfg_inval_decode
    import cfg_inval_pkg::*;
#(
    parameter int SID_W   = 32,
    parameter int SSID_W  = 20,
    parameter int RANGE_W = 5
) (
    input  logic [2:0]         op,
    input  logic [SID_W-1:0]   sid,
    input  logic [SSID_W-1:0]  ssid,
    input  logic [RANGE_W-1:0] rng,
    output cmd_plan_e          plan,
    output inv_kind_e          single_kind,
    output logic [SID_W-1:0]   single_sid,
    output logic [SSID_W-1:0]  single_ssid,
    output logic [SID_W-1:0]   walk_first,
    output logic [SID_W-1:0]   walk_last
);
    localparam logic [RANGE_W-1:0] RANGE_ALL = {RANGE_W{1'b1}};

    logic [RANGE_W:0] shamt;
    logic [SID_W:0]   span_mask;

    assign shamt      = {1'b0, rng} + 1'b1;
    assign span_mask  = ({{SID_W{1'b0}}, 1'b1} << shamt) - 1'b1;
    assign walk_first = sid & ~span_mask[SID_W-1:0];
    assign walk_last  = walk_first | span_mask[SID_W-1:0];

    always_comb begin
        plan        = PLAN_NONE;
        single_kind = INV_BY_SID;
        single_sid  = sid;
        single_ssid = '0;
        unique case (op)
            CMD_ONE_SID, CMD_SID_ALLSS: begin
                plan = PLAN_SINGLE;
            end
            CMD_SID_SSID: begin
                plan        = PLAN_SINGLE;
                single_kind = INV_BY_SID_SSID;
                single_ssid = ssid;
            end
            CMD_SID_RANGE: begin
                if (rng == RANGE_ALL) begin
                    plan        = PLAN_SINGLE;
                    single_kind = INV_EVERYTHING;
                    single_sid  = '0;
                end else begin
                    plan = PLAN_WALK;
                end
            end
            default: plan = PLAN_NONE;
        endcase
    end

endmodule

// File: rtl/cfg_inval_walk_ctr.sv
module cfg_inval_walk_ctr #(
    parameter int SID_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SID_W-1:0] first,
    input  logic [SID_W-1:0] last,
    input  logic             step,
    output logic [SID_W-1:0] cur,
    output logic             at_last
);
    // one spare bit so first+1 at the top of the ID space cannot wrap
    localparam int CW = SID_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= {1'b0, first} + 1'b1;
            lim_q <= {1'b0, last};
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cur     = cnt_q[SID_W-1:0];
    assign at_last = (cnt_q == lim_q);

endmodule

// File: rtl/cfg_inval_fanout.sv
module cfg_inval_fanout #(
    parameter int NUM_DEV = 4
) (
    input  logic               strobe,
    output logic [NUM_DEV-1:0] micro_vld,
    output logic [NUM_DEV-1:0] main_vld
);
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        assign micro_vld[d] = strobe;
        assign main_vld[d]  = strobe;
    end

endmodule

// File: rtl/cfg_inval_seq.sv
module cfg_inval_seq
    import cfg_inval_pkg::*;
#(
    parameter int NUM_DEV = 4,
    parameter int SID_W   = 32,
    parameter int SSID_W  = 20,
    parameter int RANGE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [SID_W-1:0]   cmd_sid,
    input  logic [SSID_W-1:0]  cmd_ssid,
    input  logic [RANGE_W-1:0] cmd_range,
    output logic               cc_inv_vld,
    output logic [NUM_DEV-1:0] utlb_inv_vld,
    output logic [NUM_DEV-1:0] mtlb_inv_vld,
    output logic [1:0]         inv_op,
    output logic [SID_W-1:0]   inv_sid,
    output logic [SSID_W-1:0]  inv_ssid,
    output logic               cmd_done
);
    seq_state_e state_q, state_d;

    cmd_plan_e         plan;
    inv_kind_e         single_kind;
    logic [SID_W-1:0]  single_sid;
    logic [SSID_W-1:0] single_ssid;
    logic [SID_W-1:0]  walk_first;
    logic [SID_W-1:0]  walk_last;
    logic [SID_W-1:0]  walk_cur;
    logic              walk_at_last;
    logic              accept;

    logic              vld_q;
    inv_kind_e         op_q;
    logic [SID_W-1:0]  sid_q;
    logic [SSID_W-1:0] ssid_q;
    logic              done_q;

    cfg_inval_decode #(
        .SID_W  (SID_W),
        .SSID_W (SSID_W),
        .RANGE_W(RANGE_W)
    ) u_dec (
        .op         (cmd_op),
        .sid        (cmd_sid),
        .ssid       (cmd_ssid),
        .rng        (cmd_range),
        .plan       (plan),
        .single_kind(single_kind),
        .single_sid (single_sid),
        .single_ssid(single_ssid),
        .walk_first (walk_first),
        .walk_last  (walk_last)
    );

    assign cmd_ready = (state_q == ST_IDLE);
    assign accept    = cmd_valid && cmd_ready;

    cfg_inval_walk_ctr #(
        .SID_W(SID_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept && (plan == PLAN_WALK)),
        .first  (walk_first),
        .last   (walk_last),
        .step   (state_q == ST_WALK),
        .cur    (walk_cur),
        .at_last(walk_at_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && (plan == PLAN_WALK)) state_d = ST_WALK;
            ST_WALK: if (walk_at_last)                  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // registered strobe bundle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            op_q   <= INV_BY_SID;
            sid_q  <= '0;
            ssid_q <= '0;
            done_q <= 1'b0;
        end else begin
            vld_q  <= 1'b0;
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        unique case (plan)
                            PLAN_SINGLE: begin
                                vld_q  <= 1'b1;
                                op_q   <= single_kind;
                                sid_q  <= single_sid;
                                ssid_q <= single_ssid;
                                done_q <= 1'b1;
                            end
                            PLAN_WALK: begin
                                vld_q  <= 1'b1;
                                op_q   <= INV_BY_SID;
                                sid_q  <= walk_first;
                                ssid_q <= '0;
                            end
                            default: done_q <= 1'b1;
                        endcase
                    end
                end
                ST_WALK: begin
                    vld_q  <= 1'b1;
                    op_q   <= INV_BY_SID;
                    sid_q  <= walk_cur;
                    ssid_q <= '0;
                    done_q <= walk_at_last;
                end
                default: ;
            endcase
        end
    end

    cfg_inval_fanout #(
        .NUM_DEV(NUM_DEV)
    ) u_fan (
        .strobe   (vld_q),
        .micro_vld(utlb_inv_vld),
        .main_vld (mtlb_inv_vld)
    );

    assign cc_inv_vld = vld_q;
    assign inv_op     = op_q;
    assign inv_sid    = sid_q;
    assign inv_ssid   = ssid_q;
    assign cmd_done   = done_q;

endmodule

// File: rtl/cfg_inval_chk.sv
module cfg_inval_chk #(
    parameter int NUM_DEV = 4,
    parameter int SID_W   = 32,
    parameter int SSID_W  = 20,
    parameter int RANGE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [2:0]         cmd_op,
    input logic [SID_W-1:0]   cmd_sid,
    input logic [RANGE_W-1:0] cmd_range,
    input logic               cc_inv_vld,
    input logic [NUM_DEV-1:0] utlb_inv_vld,
    input logic [NUM_DEV-1:0] mtlb_inv_vld,
    input logic [1:0]         inv_op,
    input logic [SID_W-1:0]   inv_sid,
    input logic               cmd_done
);
    localparam logic [NUM_DEV-1:0] ALL_DEV = {NUM_DEV{1'b1}};
    localparam logic [SID_W-1:0]   ONE_SID = {{(SID_W-1){1'b0}}, 1'b1};

    // R12
    broadcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_inv_vld ? (utlb_inv_vld == ALL_DEV && mtlb_inv_vld == ALL_DEV)
                   : (utlb_inv_vld == '0 && mtlb_inv_vld == '0));

    // R7
    busy_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_ready |-> cc_inv_vld && !cmd_done);

    // R6
    walk_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cc_inv_vld && !cmd_ready) |=>
            (cc_inv_vld && inv_op == 2'd0 && inv_sid == $past(inv_sid) + ONE_SID));

    // R2
    single_sid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 3'd1) |=>
            (cc_inv_vld && inv_op == 2'd0 && inv_sid == $past(cmd_sid) && cmd_done));

    // R5
    all_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 3'd2 && (&cmd_range)) |=>
            (cc_inv_vld && inv_op == 2'd2 && cmd_done && cmd_ready));

    // R10
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && (cmd_op == 3'd0 || cmd_op > 3'd4)) |=>
            (!cc_inv_vld && cmd_done));

endmodule

bind cfg_inval_seq cfg_inval_chk #(
    .NUM_DEV(NUM_DEV),
    .SID_W  (SID_W),
    .SSID_W (SSID_W),
    .RANGE_W(RANGE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_sid     (cmd_sid),
    .cmd_range   (cmd_range),
    .cc_inv_vld  (cc_inv_vld),
    .utlb_inv_vld(utlb_inv_vld),
    .mtlb_inv_vld(mtlb_inv_vld),
    .inv_op      (inv_op),
    .inv_sid     (inv_sid),
    .cmd_done    (cmd_done)
);

// File: tb/tb_cfg_inval_seq.sv
module tb_cfg_inval_seq;
    localparam int NUM_DEV = 4;
    localparam int SID_W   = 32;
    localparam int SSID_W  = 20;
    localparam int RANGE_W = 5;

    typedef struct packed {
        logic        vld;
        logic [1:0]  op;
        logic [31:0] sid;
        logic [19:0] ssid;
        logic        done;
        logic [7:0]  tag;
    } exp_t;

    typedef struct packed {
        logic        gap;
        logic [2:0]  op;
        logic [31:0] sid;
        logic [19:0] ssid;
        logic [4:0]  rng;
    } stim_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [2:0]         cmd_op = '0;
    logic [SID_W-1:0]   cmd_sid = '0;
    logic [SSID_W-1:0]  cmd_ssid = '0;
    logic [RANGE_W-1:0] cmd_range = '0;
    logic               cc_inv_vld;
    logic [NUM_DEV-1:0] utlb_inv_vld;
    logic [NUM_DEV-1:0] mtlb_inv_vld;
    logic [1:0]         inv_op;
    logic [SID_W-1:0]   inv_sid;
    logic [SSID_W-1:0]  inv_ssid;
    logic               cmd_done;

    int   n_checks = 0;
    int   n_errors = 0;
    exp_t exp_q[$];
    stim_t stim_q[$];

    always #10 clk = ~clk;

    cfg_inval_seq #(
        .NUM_DEV(NUM_DEV), .SID_W(SID_W), .SSID_W(SSID_W), .RANGE_W(RANGE_W)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_sid(cmd_sid), .cmd_ssid(cmd_ssid), .cmd_range(cmd_range),
        .cc_inv_vld(cc_inv_vld), .utlb_inv_vld(utlb_inv_vld), .mtlb_inv_vld(mtlb_inv_vld),
        .inv_op(inv_op), .inv_sid(inv_sid), .inv_ssid(inv_ssid), .cmd_done(cmd_done)
    );

    task automatic chk(input bit ok, input int tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL R%0d %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic void push(input logic v, input logic [1:0] op, input logic [31:0] sid,
                                 input logic [19:0] ssid, input logic dn, input int tag);
        exp_t e;
        e.vld = v; e.op = op; e.sid = sid; e.ssid = ssid; e.done = dn; e.tag = tag[7:0];
        exp_q.push_back(e);
    endfunction

    // reference expansion of one accepted command into a per-cycle trace
    function automatic void expand(input stim_t s);
        longint n, first;
        case (s.op)
            3'd1: push(1'b1, 2'd0, s.sid, 20'd0, 1'b1, 2);     // R2
            3'd3: push(1'b1, 2'd1, s.sid, s.ssid, 1'b1, 3);    // R3
            3'd4: push(1'b1, 2'd0, s.sid, 20'd0, 1'b1, 4);     // R4
            3'd2: begin
                if (s.rng == 5'd31) push(1'b1, 2'd2, 32'd0, 20'd0, 1'b1, 5); // R5
                else begin                                                  // R6, R8
                    n = longint'(1) << (s.rng + 1);
                    first = longint'(s.sid) & ~(n - 1);
                    for (longint i = 0; i < n; i++)
                        push(1'b1, 2'd0, 32'(first + i), 20'd0, (i == n - 1), 6);
                end
            end
            default: push(1'b0, 2'd0, 32'd0, 20'd0, 1'b1, 10); // R10
        endcase
    endfunction

    function automatic void add(input logic [2:0] op, input logic [31:0] sid,
                                input logic [19:0] ssid, input logic [4:0] rng);
        stim_t s;
        s.gap = 1'b0; s.op = op; s.sid = sid; s.ssid = ssid; s.rng = rng;
        stim_q.push_back(s);
    endfunction

    function automatic void add_gap();
        stim_t s;
        s = '0; s.gap = 1'b1;
        stim_q.push_back(s);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL R9 watchdog: actual=hung expected=all commands done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        exp_t e;
        bit   exp_rdy;
        int   idle_cycles;
        longint all_dev;
        all_dev = (longint'(1) << NUM_DEV) - 1;

        add_gap();
        add(3'd1, 32'h0000_1234, 20'h0_0abc, 5'd0);   // R2 (ssid ignored)
        add(3'd3, 32'h0000_0055, 20'h0_0007, 5'd0);   // R3
        add(3'd4, 32'h0000_0abc, 20'h0_0099, 5'd0);   // R4
        add(3'd2, 32'h1234_5678, 20'h0, 5'd31);       // R5
        add(3'd2, 32'h0000_0013, 20'h0, 5'd0);        // R6 smallest range
        add(3'd2, 32'h0000_002d, 20'h0, 5'd2);        // R6 misaligned
        add(3'd1, 32'h0000_0777, 20'h0, 5'd0);        // R7 held while busy
        add(3'd5, 32'h0000_0001, 20'h0, 5'd0);        // R10
        add(3'd0, 32'h0000_0002, 20'h0, 5'd0);        // R10
        add(3'd7, 32'h0000_0003, 20'h0, 5'd0);        // R10
        add(3'd2, 32'hffff_ffff, 20'h0, 5'd1);        // R8
        add(3'd2, 32'hffff_fff3, 20'h0, 5'd3);        // R8
        add(3'd3, 32'hdead_beef, 20'hf_ffff, 5'd0);   // R3 max ssid
        add(3'd1, 32'h0000_0000, 20'h0, 5'd0);
        add(3'd6, 32'h0000_0000, 20'h0, 5'd0);        // R10
        add_gap();
        add(3'd2, 32'h0000_013f, 20'h0, 5'd4);        // R6 32 ids
        add(3'd4, 32'h8000_0000, 20'h0, 5'd0);        // R4
        add(3'd2, 32'h0000_0000, 20'h0, 5'd31);       // R5

        // R11: reset state
        repeat (3) @(negedge clk);
        chk(cc_inv_vld == 1'b0, 11, "reset strobe", cc_inv_vld, 0);
        chk(utlb_inv_vld == '0 && mtlb_inv_vld == '0, 11, "reset dev strobes",
            {utlb_inv_vld, mtlb_inv_vld}, 0);
        chk(cmd_done == 1'b0, 11, "reset done", cmd_done, 0);
        chk(cmd_ready == 1'b1, 11, "reset ready", cmd_ready, 1);
        rst_n = 1'b1;

        idle_cycles = 0;
        while (idle_cycles < 4) begin
            @(negedge clk);
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else begin e = '0; e.tag = 8'd11; end
            exp_rdy = (exp_q.size() == 0);

            chk(cc_inv_vld == e.vld, e.tag, "config cache strobe", cc_inv_vld, e.vld);
            // R12 every interface cache strobed together
            chk(utlb_inv_vld == (e.vld ? all_dev[NUM_DEV-1:0] : '0), 12, "micro strobes",
                utlb_inv_vld, e.vld ? all_dev : 0);
            chk(mtlb_inv_vld == (e.vld ? all_dev[NUM_DEV-1:0] : '0), 12, "main strobes",
                mtlb_inv_vld, e.vld ? all_dev : 0);
            // R9 done timing
            chk(cmd_done == e.done, 9, "done", cmd_done, e.done);
            // R7 ready while walking, R1 ready when idle
            chk(cmd_ready == exp_rdy, 7, "ready", cmd_ready, exp_rdy);
            if (e.vld && cc_inv_vld) begin
                chk(inv_op == e.op, e.tag, "strobe kind", inv_op, e.op);
                chk(inv_sid == e.sid, e.tag, "strobe sid", inv_sid, e.sid);
                chk(inv_ssid == e.ssid, e.tag, "strobe ssid", inv_ssid, e.ssid);
            end

            // drive next command (R1 handshake)
            if (stim_q.size() > 0) begin
                idle_cycles = 0;
                if (stim_q[0].gap) begin
                    cmd_valid = 1'b0;
                    if (exp_rdy) void'(stim_q.pop_front());
                end else begin
                    cmd_valid = 1'b1;
                    cmd_op    = stim_q[0].op;
                    cmd_sid   = stim_q[0].sid;
                    cmd_ssid  = stim_q[0].ssid;
                    cmd_range = stim_q[0].rng;
                    if (exp_rdy) expand(stim_q.pop_front());
                end
            end else begin
                cmd_valid = 1'b0;
                if (exp_q.size() == 0) idle_cycles++;
            end
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule